// File: doc/BRIEF.md
# Actuated Two-Road Traffic Light Controller

This block drives the lamps at a crossing of a major east-west road and a minor north-south road. The major road is given right-of-way by default. Its green runs for a fixed minimum time and then stays on for as long as nobody is waiting on the minor road. A vehicle sensor on the minor road hands the crossing over through a yellow phase on the major road. The minor road then gets a green phase with an upper time limit. That green ends early once the sensor goes quiet, and a yellow phase follows before right-of-way returns to the major road.

All phase timing counts one-second ticks. These come from an external enable pulse that is high for one clock cycle each second. A single down-counter holds the seconds left in the current phase. The counter is shown as two BCD digits, and the same digits are also decoded for two seven-segment displays. During the open-ended major-road hold, the display reads 00. The sensor input is asynchronous, so it passes through a two-flop synchronizer before any decision uses it.

Top module: `junction_signal_ctrl`

## Requirements
- R1: On the cycle after a synchronous reset, the east-west road shows green and the north-south road shows red, and the display reads 40.
- R2: The east-west green lasts exactly MAJOR_MIN (40) ticks before it can end. The minor-road sensor has no effect during that time.
- R3: After the minimum, if the synchronized sensor is low, the east-west green is held indefinitely and the display reads 00. A demand seen on any clock cycle of this hold starts the east-west yellow on the next cycle, without waiting for a tick.
- R4: If demand is present when the minimum expires, or arrives during the hold, the east-west road shows yellow for exactly AMBER_SECS (4) ticks. The north-south road then goes green, and the display loads 20.
- R5: With demand held high, the north-south green lasts MINOR_MAX (20) ticks. The north-south road then shows yellow for 4 ticks, after which the east-west road returns to green and the display reads 40.
- R6: During the north-south green, a low synchronized sensor ends the green on the next clock cycle, whether or not a tick occurs. The north-south yellow then starts with 4 seconds loaded.
- R7: The sensor passes through two flops, so a change on minor_req affects the phase decisions two clock cycles later.
- R8: The phase and the remaining-seconds count change only on tick cycles. The exceptions are the demand-driven exits of R3 and R6.
- R9: Each road lights exactly one lamp at a time. The two roads are never non-red together. A road turns green only after the other road has shown yellow.
- R10: bcd_tens and bcd_ones give the remaining seconds in decimal. Each seven-segment output is active-high with bit 0 = segment a through bit 6 = segment g. The codes for digits 0-9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second enable pulse |
| minor_req | input | 1 | Vehicle present on the north-south road (asynchronous) |
| ew_red | output | 1 | East-west red lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_green | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_green | output | 1 | North-south green lamp |
| bcd_tens | output | 4 | Tens digit of the remaining seconds |
| bcd_ones | output | 4 | Ones digit of the remaining seconds |
| seg_tens | output | 7 | Seven-segment pattern of the tens digit |
| seg_ones | output | 7 | Seven-segment pattern of the ones digit |

## Verification
The stimulus phases are chosen to separate the behaviours:
- A request raised early and held throughout shows that the minimum green ignores the sensor. It also shows that the minor green runs to its full limit.
- A long quiet spell exposes the open-ended hold and the 00 display.
- A request that is dropped partway through the minor green separates an early, tick-independent termination from a timed one.
- Sparse ticks and then random ticks with a randomly changing sensor show that counting follows only the tick enable. They also show that the demand-driven exits and the two-cycle sensor delay land on the right cycle.

// File: rtl/junction_signal_ctrl.sv
`timescale 1ns/1ps
module junction_signal_ctrl #(
  parameter int MAJOR_MIN  = 40,
  parameter int AMBER_SECS = 4,
  parameter int MINOR_MAX  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       minor_req,
  output logic       ew_red,
  output logic       ew_yellow,
  output logic       ew_green,
  output logic       ns_red,
  output logic       ns_yellow,
  output logic       ns_green,
  output logic [3:0] bcd_tens,
  output logic [3:0] bcd_ones,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_ones
);

  localparam int LONGEST = (MAJOR_MIN > MINOR_MAX) ?
                           ((MAJOR_MIN > AMBER_SECS) ? MAJOR_MIN : AMBER_SECS) :
                           ((MINOR_MAX > AMBER_SECS) ? MINOR_MAX : AMBER_SECS);
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] LD_MAJ = CW'(MAJOR_MIN);
  localparam logic [CW-1:0] LD_AMB = CW'(AMBER_SECS);
  localparam logic [CW-1:0] LD_MIN = CW'(MINOR_MAX);
  localparam logic [CW-1:0] ONE    = CW'(1);

  typedef enum logic [2:0] {P_EW_GO, P_EW_HOLD, P_EW_AMB, P_NS_GO, P_NS_AMB} phase_t;

  phase_t        phase;
  logic [CW-1:0] remain;
  logic [1:0]    sync;
  logic          demand, last_sec;

  assign demand   = sync[1];
  assign last_sec = tick && (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= P_EW_GO;
      remain <= LD_MAJ;
      sync   <= 2'b00;
    end else begin
      sync <= {sync[0], minor_req};
      case (phase)
        P_EW_GO:
          if (last_sec) begin
            if (demand) begin
              phase  <= P_EW_AMB;
              remain <= LD_AMB;
            end else begin
              phase  <= P_EW_HOLD;
              remain <= '0;
            end
          end else if (tick) remain <= remain - ONE;
        P_EW_HOLD:
          if (demand) begin
            phase  <= P_EW_AMB;
            remain <= LD_AMB;
          end
        P_EW_AMB:
          if (last_sec) begin
            phase  <= P_NS_GO;
            remain <= LD_MIN;
          end else if (tick) remain <= remain - ONE;
        P_NS_GO:
          if (!demand || last_sec) begin
            phase  <= P_NS_AMB;
            remain <= LD_AMB;
          end else if (tick) remain <= remain - ONE;
        P_NS_AMB:
          if (last_sec) begin
            phase  <= P_EW_GO;
            remain <= LD_MAJ;
          end else if (tick) remain <= remain - ONE;
        default: begin
          phase  <= P_EW_GO;
          remain <= LD_MAJ;
        end
      endcase
    end
  end

  assign ew_green  = (phase == P_EW_GO) || (phase == P_EW_HOLD);
  assign ew_yellow = (phase == P_EW_AMB);
  assign ew_red    = !(ew_green || ew_yellow);
  assign ns_green  = (phase == P_NS_GO);
  assign ns_yellow = (phase == P_NS_AMB);
  assign ns_red    = !(ns_green || ns_yellow);

  assign bcd_tens = 4'(remain / CW'(10));
  assign bcd_ones = 4'(remain % CW'(10));

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: seg7 = 7'h3F;
      4'd1: seg7 = 7'h06;
      4'd2: seg7 = 7'h5B;
      4'd3: seg7 = 7'h4F;
      4'd4: seg7 = 7'h66;
      4'd5: seg7 = 7'h6D;
      4'd6: seg7 = 7'h7D;
      4'd7: seg7 = 7'h07;
      4'd8: seg7 = 7'h7F;
      4'd9: seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  assign seg_tens = seg7(bcd_tens);
  assign seg_ones = seg7(bcd_ones);

  p_min_green_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == P_EW_GO && !last_sec) |=> (phase == P_EW_GO));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == P_EW_HOLD && !demand) |=> (phase == P_EW_HOLD && remain == '0));

  p_amber_load_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ew_yellow) |-> (remain == LD_AMB));

  p_ns_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ns_green) |-> ($past(ew_yellow) && remain == LD_MIN));

  p_early_end_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == P_NS_GO && !demand) |=> (phase == P_NS_AMB && remain == LD_AMB));

  p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && phase != P_EW_HOLD && !(phase == P_NS_GO && !demand)) |=> $stable(remain));

  p_ew_return_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ew_green) |-> $past(ns_yellow));

endmodule

// File: tb/junction_signal_ctrl_test.sv
`timescale 1ns/1ps
module junction_signal_ctrl_test;
  logic clk = 0, rst = 1, tick = 0, minor_req = 0;
  logic ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green;
  logic [3:0] bcd_tens, bcd_ones;
  logic [6:0] seg_tens, seg_ones;

  junction_signal_ctrl uut (.*);

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  // reference model: 0 EW green timed, 1 EW hold, 2 EW yellow, 3 NS green, 4 NS yellow
  int ph = 0, left = 40;
  bit s1 = 0, s2 = 0;
  int since_rst = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; left = 40; s1 = 0; s2 = 0; since_rst = 0;
    end else begin
      bit d;
      d = s2; s2 = s1; s1 = minor_req;   // R7: two-cycle sensor delay
      since_rst++;
      case (ph)
        0: if (tick) begin
             if (left == 1) begin
               if (d) begin ph = 2; left = 4; end else begin ph = 1; left = 0; end
             end else left--;
           end
        1: if (d) begin ph = 2; left = 4; end
        2: if (tick) begin if (left == 1) begin ph = 3; left = 20; end else left--; end
        3: if (!d) begin ph = 4; left = 4; end
           else if (tick) begin if (left == 1) begin ph = 4; left = 4; end else left--; end
        default: if (tick) begin if (left == 1) begin ph = 0; left = 40; end else left--; end
      endcase
    end
  end

  function automatic logic [6:0] seg_of(input int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return t[d];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      int exp_lamps, act_lamps;
      if (since_rst == 1) tag = "R1";
      else case (ph)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5/R6";
        default: tag = "R5";
      endcase
      exp_lamps = {ph <= 1, ph == 2, ph >= 3, ph == 3, ph == 4, ph <= 2};
      act_lamps = {ew_green, ew_yellow, ew_red, ns_green, ns_yellow, ns_red};
      check(tag, "lamps {ewG,ewY,ewR,nsG,nsY,nsR}", act_lamps, exp_lamps);
      check("R9", "one lamp per road, never both non-red",
            {($countones({ew_red, ew_yellow, ew_green}) == 1),
             ($countones({ns_red, ns_yellow, ns_green}) == 1),
             (ew_red || ns_red)}, 3'b111);
      check(since_rst == 1 ? "R1" : "R8", "bcd digits", {bcd_tens, bcd_ones},
            ((left / 10) << 4) | (left % 10));
      check("R10", "segments", {seg_tens, seg_ones},
            (int'(seg_of(left / 10)) << 7) | int'(seg_of(left % 10)));
    end
  end

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (every == 0) ? ($urandom % 3 == 0) : (i % every == 0);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                          // R1 checked on the first compare
    run(5, 1);
    minor_req = 1;                    // R2: request during minimum is ignored
    run(90, 1);                       // R4 then R5: full 20-tick minor green
    minor_req = 0;
    run(150, 1);                      // R3: indefinite hold, display 00
    run(7, 0);
    minor_req = 1;                    // R3/R7: exit without tick, two cycles later
    for (int i = 0; i < 200 && !ns_green; i++) run(1, 1);
    run(6, 1);
    run(3, 0);
    minor_req = 0;                    // R6: early end of minor green
    run(80, 1);
    for (int k = 0; k < 20; k++) begin   // R8: sparse ticks
      minor_req = (k % 3 != 0);
      run(97, 4);
    end
    for (int k = 0; k < 150; k++) begin  // random ticks and sensor
      minor_req = $urandom % 2;
      run(1 + $urandom % 25, 0);
    end
    rst = 1;
    run(2, 1);
    rst = 0;                          // R1 again after mid-run reset
    run(30, 1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end
endmodule